// File: doc/BRIEF.md
# Multidrop Address Wake-Up Filter

This block sits behind a 9-bit asynchronous receiver on a shared half-duplex bus with one master and many slave nodes. Each received character carries a ninth bit that marks it as an address character (bit 8 = 1) or a data character (bit 8 = 0). The filter sleeps through all bus traffic until an address character names this node. Only then does it hand the payload bytes on to the local consumer. Frames sent to other nodes are dropped on arrival and never reach any storage.

The filter evaluates every address character against a configurable own address and against the all-ones broadcast value. On a hit it pulses a wake event and opens a frame. The data bytes that follow leave on a registered byte stream. The first byte of each frame is flagged. A level flag marks broadcast frames. A configurable length cap guards against corrupt frames. Once a frame has delivered the allowed number of bytes, the filter drops everything until the next address character.

Top module: `mwf_filter`

## Requirements
- R1: A character with bit 8 = 1 is an address character whose address is bits 7..0. A character with bit 8 = 0 is a data character. A data character never acts as an address, even when its low byte equals the own address.
- R2: After reset, and before any matching address, every data character is ignored: `out_valid_o` stays 0.
- R3: An address character that differs from both `own_addr_i` and 0xFF returns the filter to sleep. The data characters that follow produce no output.
- R4: After a matching address, each data character appears on `out_data_o` with `out_valid_o` = 1 one clock after it is accepted. `out_sof_o` is 1 with the first byte of the frame only. Cycles with `rx_valid_i` = 0 produce no output.
- R5: An address character that arrives during a frame ends that frame. In the same cycle it is evaluated as a new address: a hit restarts the frame, and its next byte carries `out_sof_o` again. A miss makes the filter sleep.
- R6: Address 0xFF always matches. `bcast_o` is 1 from the wake pulse of a broadcast frame until the frame ends through an address character or an overlength drop. For any other frame `bcast_o` is 0.
- R7: A frame forwards at most `max_len_i` data bytes. Further data characters produce no output until the next address character. When the frame is dropped this way, `bcast_o` returns to 0.
- R8: Each matching address character produces exactly one cycle of `wake_o` = 1, one clock after it is accepted. A non-matching address gives no pulse.
- R9: While `rst_ni` is low, all outputs are 0 and the filter is asleep. A reset in the middle of a frame discards the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Strobe for one received character |
| rx_char_i | input | DATA_W+1 | Received character; top bit marks an address |
| own_addr_i | input | DATA_W | Address of this node |
| max_len_i | input | LEN_W | Maximum number of data bytes per frame |
| out_valid_o | output | 1 | Forwarded byte is present |
| out_data_o | output | DATA_W | Forwarded byte |
| out_sof_o | output | 1 | First byte of a frame |
| bcast_o | output | 1 | The current frame is a broadcast |
| wake_o | output | 1 | One-cycle pulse on an address match |

## Verification
A wrong sleep/forward state shows at the ports one clock after the next data character. A node that wrongly thinks it is awake emits a stray `out_valid_o`. A node that wrongly thinks it is asleep drops a byte the bench expects. A stale byte counter shows up as a frame that is truncated early or runs past the cap. A first-byte marker that is left set or is lost shows on `out_sof_o` with the next forwarded byte. The stimulus therefore interleaves foreign frames, frames cut short by an address, broadcasts, and frames that run over the cap. Every state is followed at once by a data character that shows it.

// File: rtl/mwf_pkg.sv
package mwf_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_FWD   = 2'd1,
    ST_DROP  = 2'd2
  } mwf_state_e;
endpackage

// File: rtl/mwf_char_decode.sv
module mwf_char_decode #(
  parameter int DATA_W = 8
) (
  input  logic              valid_i,
  input  logic [DATA_W:0]   char_i,
  input  logic [DATA_W-1:0] own_addr_i,
  output logic              is_addr_o,
  output logic              is_data_o,
  output logic              hit_o,
  output logic              hit_bcast_o
);
  localparam logic [DATA_W-1:0] BcastAddr = '1;

  logic [DATA_W-1:0] addr;

  assign addr        = char_i[DATA_W-1:0];
  assign is_addr_o   = valid_i &&  char_i[DATA_W];
  assign is_data_o   = valid_i && !char_i[DATA_W];
  assign hit_bcast_o = is_addr_o && (addr == BcastAddr);
  assign hit_o       = is_addr_o && ((addr == own_addr_i) || (addr == BcastAddr));
endmodule

// File: rtl/mwf_len_guard.sv
module mwf_len_guard #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] max_len_i,
  output logic             at_limit_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit_o = (cnt_q >= max_len_i);
endmodule

// File: rtl/mwf_fsm.sv
module mwf_fsm
  import mwf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              is_addr_i,
  input  logic              is_data_i,
  input  logic              hit_i,
  input  logic              hit_bcast_i,
  input  logic              at_limit_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              fwd_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              bcast_o,
  output logic              wake_o
);
  mwf_state_e state_q, state_d;
  logic first_q, overrun;

  // Address characters are decoded in every state, which also ends a running frame.
  always_comb begin
    state_d = state_q;
    fwd_o   = 1'b0;
    overrun = 1'b0;
    if (is_addr_i) begin
      state_d = hit_i ? ST_FWD : ST_SLEEP;
    end else if (is_data_i && state_q == ST_FWD) begin
      if (at_limit_i) begin
        state_d = ST_DROP;
        overrun = 1'b1;
      end else begin
        fwd_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_SLEEP;
      first_q     <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_sof_o   <= 1'b0;
      bcast_o     <= 1'b0;
      wake_o      <= 1'b0;
    end else begin
      state_q     <= state_d;
      out_valid_o <= fwd_o;
      out_sof_o   <= fwd_o && first_q;
      wake_o      <= hit_i;
      if (fwd_o) out_data_o <= byte_i;
      if (is_addr_i)  first_q <= hit_i;
      else if (fwd_o) first_q <= 1'b0;
      if (is_addr_i)    bcast_o <= hit_bcast_i;
      else if (overrun) bcast_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mwf_filter.sv
module mwf_filter #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W:0]   rx_char_i,
  input  logic [DATA_W-1:0] own_addr_i,
  input  logic [LEN_W-1:0]  max_len_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              bcast_o,
  output logic              wake_o
);
  logic is_addr, is_data, hit, hit_bcast, at_limit, fwd;

  mwf_char_decode #(.DATA_W(DATA_W)) i_dec (
    .valid_i     (rx_valid_i),
    .char_i      (rx_char_i),
    .own_addr_i  (own_addr_i),
    .is_addr_o   (is_addr),
    .is_data_o   (is_data),
    .hit_o       (hit),
    .hit_bcast_o (hit_bcast)
  );

  mwf_len_guard #(.LEN_W(LEN_W)) i_len (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (is_addr),
    .inc_i      (fwd),
    .max_len_i  (max_len_i),
    .at_limit_o (at_limit)
  );

  mwf_fsm #(.DATA_W(DATA_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .is_addr_i   (is_addr),
    .is_data_i   (is_data),
    .hit_i       (hit),
    .hit_bcast_i (hit_bcast),
    .at_limit_i  (at_limit),
    .byte_i      (rx_char_i[DATA_W-1:0]),
    .fwd_o       (fwd),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_sof_o   (out_sof_o),
    .bcast_o     (bcast_o),
    .wake_o      (wake_o)
  );
endmodule

// File: rtl/mwf_filter_chk.sv
module mwf_filter_chk #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic [DATA_W:0]   rx_char_i,
  input logic [DATA_W-1:0] own_addr_i,
  input logic [LEN_W-1:0]  max_len_i,
  input logic              out_valid_o,
  input logic              out_sof_o,
  input logic              bcast_o,
  input logic              wake_o
);
  localparam logic [DATA_W-1:0] BcastAddr = '1;

  logic [LEN_W:0] frm_cnt_q;
  logic           awake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_cnt_q <= '0;
      awake_q   <= 1'b0;
    end else begin
      if (wake_o)           frm_cnt_q <= '0;
      else if (out_valid_o) frm_cnt_q <= frm_cnt_q + 1'b1;
      if (rx_valid_i && rx_char_i[DATA_W]) awake_q <= 1'b0;
      if (wake_o)                          awake_q <= 1'b1;
    end
  end

  a_r1_data_never_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(rx_valid_i && rx_char_i[DATA_W]));

  a_r4_out_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(rx_valid_i && !rx_char_i[DATA_W]));

  a_r4_sof_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sof_o |-> out_valid_o);

  a_r6_bcast_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && $past(rx_char_i[DATA_W-1:0] == BcastAddr)) |-> bcast_o);

  a_r7_len_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ({1'b0, max_len_i} > frm_cnt_q));

  a_r8_wake_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ($past(rx_char_i[DATA_W-1:0] == own_addr_i) ||
                $past(rx_char_i[DATA_W-1:0] == BcastAddr)));

  a_r2_sleep_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!awake_q && !wake_o) |-> !out_valid_o);
endmodule

bind mwf_filter mwf_filter_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .rx_char_i   (rx_char_i),
  .own_addr_i  (own_addr_i),
  .max_len_i   (max_len_i),
  .out_valid_o (out_valid_o),
  .out_sof_o   (out_sof_o),
  .bcast_o     (bcast_o),
  .wake_o      (wake_o)
);

// File: tb/test_mwf_filter.sv
`timescale 1ns/1ps
module test_mwf_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [8:0] rx_char = '0;
  logic [7:0] own_addr = 8'h12;
  logic [7:0] max_len = 8'd4;
  logic       out_valid, out_sof, bcast, wake;
  logic [7:0] out_data;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  mwf_filter i_mwf_filter (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_char_i(rx_char),
    .own_addr_i(own_addr), .max_len_i(max_len), .out_valid_o(out_valid),
    .out_data_o(out_data), .out_sof_o(out_sof), .bcast_o(bcast), .wake_o(wake)
  );

  // {valid, char[8:0], exp_valid, exp_data, exp_sof, exp_wake, exp_bcast}
  localparam int NV = 21;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 9'h012, 1'b0, 8'h00, 3'b000},  // R1 data equal to own addr: ignored
    {1'b1, 9'h134, 1'b0, 8'h00, 3'b000},  // R3 foreign address
    {1'b1, 9'h066, 1'b0, 8'h00, 3'b000},  // R3 foreign data dropped
    {1'b1, 9'h112, 1'b0, 8'h00, 3'b010},  // R8 own address wakes
    {1'b1, 9'h0A1, 1'b1, 8'hA1, 3'b100},  // R4 first byte
    {1'b1, 9'h0A2, 1'b1, 8'hA2, 3'b000},  // R4
    {1'b0, 9'h0EE, 1'b0, 8'h00, 3'b000},  // R4 idle cycle
    {1'b1, 9'h0A3, 1'b1, 8'hA3, 3'b000},  // R4
    {1'b1, 9'h134, 1'b0, 8'h00, 3'b000},  // R5 foreign address ends frame
    {1'b1, 9'h077, 1'b0, 8'h00, 3'b000},  // R5 now asleep
    {1'b1, 9'h112, 1'b0, 8'h00, 3'b010},  // R8
    {1'b1, 9'h1FF, 1'b0, 8'h00, 3'b011},  // R6 broadcast while forwarding
    {1'b1, 9'h0B1, 1'b1, 8'hB1, 3'b101},  // R6
    {1'b1, 9'h0B2, 1'b1, 8'hB2, 3'b001},
    {1'b1, 9'h0B3, 1'b1, 8'hB3, 3'b001},
    {1'b1, 9'h0B4, 1'b1, 8'hB4, 3'b001},  // R7 fourth byte, at cap
    {1'b1, 9'h0B5, 1'b0, 8'h00, 3'b000},  // R7 over cap dropped, bcast clears
    {1'b1, 9'h0B6, 1'b0, 8'h00, 3'b000},  // R7
    {1'b1, 9'h112, 1'b0, 8'h00, 3'b010},  // R7 address resumes
    {1'b1, 9'h0C1, 1'b1, 8'hC1, 3'b100},
    {1'b1, 9'h133, 1'b0, 8'h00, 3'b000}   // R3
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [8:0] c);
    @(negedge clk);
    rx_valid = v;
    rx_char  = c;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string req, logic v, logic [7:0] d, logic s, logic w, logic b);
    chk({req, " valid"}, {7'd0, out_valid}, {7'd0, v});
    if (v) chk({req, " data"}, out_data, d);
    chk({req, " sof"}, {7'd0, out_sof}, {7'd0, s});
    chk({req, " wake"}, {7'd0, wake}, {7'd0, w});
    chk({req, " bcast"}, {7'd0, bcast}, {7'd0, b});
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12;
    expect_out("R9 in reset", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 9'h055);
    expect_out("R2 data after reset", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21], VEC[i][20:12]);
      expect_out($sformatf("R1-vector %0d", i), VEC[i][11], VEC[i][10:3],
                 VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R5: own address during frame restarts it, sof again
    step(1'b1, 9'h112); expect_out("R5 wake", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    step(1'b1, 9'h0D1); expect_out("R5 first", 1'b1, 8'hD1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 9'h112); expect_out("R5 rewake", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    step(1'b1, 9'h0D2); expect_out("R5 sof again", 1'b1, 8'hD2, 1'b1, 1'b0, 1'b0);
    step(1'b0, 9'h000); expect_out("R8 pulse one cycle", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);

    // R7: cap of one byte
    max_len = 8'd1;
    step(1'b1, 9'h112); expect_out("R7 wake", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    step(1'b1, 9'h0E1); expect_out("R7 only byte", 1'b1, 8'hE1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 9'h0E2); expect_out("R7 over cap", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    max_len = 8'd4;

    // R9: reset mid-frame discards it
    step(1'b1, 9'h112); expect_out("R9 wake", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b0; rx_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 9'h0F1); expect_out("R9 frame gone", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule